// File: doc/BRIEF.md
# Mantissa-Exponent Token Bucket Shaper

This block shapes traffic for one queue or scheduler node with a single credit bucket. A set of parameters in a compact floating-point-like code sets both how quickly credit refills and how large the bucket may grow. Each value is (256 + mantissa) shifted left by an exponent, in units of 1/256 of a credit unit. An external base timebase supplies tick strobes, nominally two million per second. The refill is spread over 2^div ticks, so the effective rate is 2e6 × ((256 + m) << e) / 256 / 2^div credit units per second.

For each packet the caller presents a length and a mode bit. In packet-count mode a packet costs exactly one credit unit. In byte mode it costs its length plus a configured signed adjustment. The block reports combinationally whether the bucket holds enough credit. When the caller strobes send on a conforming packet, the cost is debited in the same clock edge. A parameter reload captures a new configuration, fills the bucket to its new cap and restarts the tick divider.

Top module: `mx_shaper`

## Requirements
- R1: After reset the credit level reads 512 (two units; cap of an all-zero burst code), the divider is empty and the refill code is mantissa 0, exponent 0, divider 0.
- R2: A cycle with cfg_load high captures all configuration inputs. On the following edge the credit level equals the new cap, (256 + burst_mant) << (burst_exp + 1), in 1/256 units, and the tick divider restarts from zero.
- R3: Each refill event adds (256 + rate_mant) << rate_exp to credit_level, which counts in 1/256 of a unit (8 fractional bits), so fractional refills such as 257 are kept exactly.
- R4: A refill event occurs on every 2^div-th base_tick counted since reset or the last load; base_tick pulses in between change nothing.
- R5: A cfg_div_exp above 12 behaves exactly as 12.
- R6: After a refill the credit saturates at the cap and never wraps.
- R7: pkt_conform is high exactly when credit_level >= cost (equality conforms); a send on a non-conforming packet leaves the credit unchanged.
- R8: A send on a conforming packet subtracts its cost (in 1/256 units) at that clock edge.
- R9: With pkt_count_mode high the cost is 256 (one unit) regardless of pkt_len and the adjustment.
- R10: With pkt_count_mode low the cost is (pkt_len + adj) × 256. The captured adj is clamped to the range [1 − MIN_FRAME, +255] (MIN_FRAME defaults to 60, so the range is −59..255). An adjusted length below zero costs zero.
- R11: When a refill and a debit coincide, the refill is added first, then the sum saturates at the cap, then the cost is subtracted. A load in the same cycle as a send overrides the debit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture configuration, refill bucket to cap, restart divider |
| cfg_rate_mant | input | 8 | Refill mantissa |
| cfg_rate_exp | input | 4 | Refill exponent |
| cfg_div_exp | input | 4 | Refill spread exponent (values above 12 act as 12) |
| cfg_burst_mant | input | 8 | Bucket cap mantissa |
| cfg_burst_exp | input | 4 | Bucket cap exponent |
| cfg_len_adj | input | 9 | Signed byte-mode length adjustment |
| base_tick | input | 1 | Base timebase strobe |
| pkt_len | input | 16 | Packet length in bytes |
| pkt_count_mode | input | 1 | 1: packet costs one unit; 0: byte cost |
| pkt_send | input | 1 | Packet is sent this cycle |
| pkt_conform | output | 1 | Credit covers the presented packet's cost |
| credit_level | output | 26 | Current bucket credit in 1/256 units |

## Verification
The bench goes after the cycle where a tick refill and a debit coincide at the cap. A design that subtracted before saturating would end at the cap instead of 256 below it. It checks the equality boundary of the conform test, which an off-by-one comparator would reject. It uses a fractional refill of 257 that a truncating design would round. A reload halfway through a divide window would delay or advance the next refill if the divider were not cleared. An oversized divider exponent would either never refill or refill early. The adjustment clamp, the floor at zero and the largest rate and cap codes are probed at the credit level, where a sign-extension or width error shows as a wrong balance.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int MANT_W = 8;
  localparam int EXP_W  = 4;
  localparam int FRAC_W = 8;
  // (256+m) needs MANT_W+1 bits, shifted by up to 2^EXP_W, one bit headroom for sums
  localparam int CRED_W = MANT_W + 2 + (1 << EXP_W);

  typedef logic [CRED_W-1:0] credit_t;

  // (256 + m) << sh, in 1/256 units
  function automatic credit_t me_value(input logic [MANT_W-1:0] m,
                                       input logic [EXP_W:0]    sh);
    credit_t base;
    base = credit_t'({1'b1, m});
    return base << sh;
  endfunction

endpackage

// File: rtl/shp_tick_div.sv
module shp_tick_div #(
  parameter int DIV_MAX = 12,
  parameter int DIVX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              base_tick,
  input  logic [DIVX_W-1:0] div_exp,
  output logic              refill_evt
);

  localparam int CNT_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DIVX_W-1:0] div_eff;
  logic [CNT_W:0]    span;
  logic [CNT_W-1:0]  limit;

  always_comb begin
    if (div_exp > DIVX_W'(DIV_MAX)) div_eff = DIVX_W'(DIV_MAX);
    else                             div_eff = div_exp;
    span  = (CNT_W+1)'(1) << div_eff;
    limit = CNT_W'(span - (CNT_W+1)'(1));
  end

  assign refill_evt = base_tick && !clear && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)           cnt_d = '0;
    else if (refill_evt) cnt_d = '0;
    else if (base_tick)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R4

  AST_QUIET_NO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !clear) |=> (cnt_q == $past(cnt_q))); // R4

endmodule

// File: rtl/shp_cost.sv
module shp_cost
  import shp_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ADJ_W = 9
) (
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic                    count_mode,
  input  logic signed [ADJ_W-1:0] adj,
  output credit_t                 cost
);

  localparam int SUM_W = ((LEN_W > ADJ_W) ? LEN_W : ADJ_W) + 2;

  logic signed [SUM_W-1:0] len_s, adj_s, sum_s;
  logic        [SUM_W-1:0] len_pos;

  always_comb begin
    len_s = SUM_W'($signed({1'b0, pkt_len}));
    adj_s = SUM_W'(adj);
    sum_s = len_s + adj_s;
    if (sum_s < 0) len_pos = '0;
    else           len_pos = SUM_W'(sum_s);
    if (count_mode) cost = credit_t'(1) << FRAC_W;
    else            cost = credit_t'(len_pos) << FRAC_W;
  end

endmodule

// File: rtl/shp_bucket.sv
module shp_bucket
  import shp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  credit_t new_cap,
  input  logic    refill_evt,
  input  credit_t refill_amt,
  input  logic    send,
  input  credit_t cost,
  output logic    conform,
  output credit_t credit
);

  localparam credit_t RESET_CAP = credit_t'(512);

  credit_t credit_q, credit_d;
  credit_t cap_q, cap_d;
  credit_t sum, sat;

  assign conform = (credit_q >= cost);
  assign credit  = credit_q;

  always_comb begin
    cap_d = load ? new_cap : cap_q;
    sum   = credit_q + (refill_evt ? refill_amt : credit_t'(0));
    sat   = (sum > cap_q) ? cap_q : sum;
    if (load)                  credit_d = new_cap;
    else if (send && conform)  credit_d = sat - cost;
    else                       credit_d = sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= RESET_CAP;
      cap_q    <= RESET_CAP;
    end else begin
      credit_q <= credit_d;
      cap_q    <= cap_d;
    end
  end

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= cap_q); // R6

  AST_LOAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (credit_q == cap_q)); // R2

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !conform && !load && !refill_evt) |=> $stable(credit_q)); // R7

  AST_DEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (send && conform && !load && !refill_evt) |=>
      (credit_q == $past(credit_q) - $past(cost))); // R8

  AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (send && conform && !load && refill_evt) |=>
      (credit_q + $past(cost) <= $past(cap_q))); // R11

endmodule

// File: rtl/mx_shaper.sv
module mx_shaper
  import shp_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int ADJ_W     = 9,
  parameter int MIN_FRAME = 60,
  parameter int DIV_MAX   = 12,
  parameter int DIVX_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [MANT_W-1:0]       cfg_rate_mant,
  input  logic [EXP_W-1:0]        cfg_rate_exp,
  input  logic [DIVX_W-1:0]       cfg_div_exp,
  input  logic [MANT_W-1:0]       cfg_burst_mant,
  input  logic [EXP_W-1:0]        cfg_burst_exp,
  input  logic signed [ADJ_W-1:0] cfg_len_adj,
  input  logic                    base_tick,
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic                    pkt_count_mode,
  input  logic                    pkt_send,
  output logic                    pkt_conform,
  output logic [CRED_W-1:0]       credit_level
);

  localparam logic signed [ADJ_W-1:0] ADJ_LO = ADJ_W'(1 - MIN_FRAME);
  localparam logic signed [ADJ_W-1:0] ADJ_HI = ADJ_W'(255);

  logic [MANT_W-1:0]       rate_m_q, rate_m_d;
  logic [EXP_W-1:0]        rate_e_q, rate_e_d;
  logic [DIVX_W-1:0]       div_q, div_d;
  logic signed [ADJ_W-1:0] adj_q, adj_d, adj_clamped;

  credit_t new_cap, refill_amt, cost, credit;
  logic    refill_evt;

  always_comb begin
    if (cfg_len_adj < ADJ_LO)      adj_clamped = ADJ_LO;
    else if (cfg_len_adj > ADJ_HI) adj_clamped = ADJ_HI;
    else                           adj_clamped = cfg_len_adj;
  end

  always_comb begin
    rate_m_d = rate_m_q;
    rate_e_d = rate_e_q;
    div_d    = div_q;
    adj_d    = adj_q;
    if (cfg_load) begin
      rate_m_d = cfg_rate_mant;
      rate_e_d = cfg_rate_exp;
      div_d    = cfg_div_exp;
      adj_d    = adj_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_m_q <= '0;
      rate_e_q <= '0;
      div_q    <= '0;
      adj_q    <= '0;
    end else begin
      rate_m_q <= rate_m_d;
      rate_e_q <= rate_e_d;
      div_q    <= div_d;
      adj_q    <= adj_d;
    end
  end

  assign new_cap    = me_value(cfg_burst_mant, {1'b0, cfg_burst_exp} + (EXP_W+1)'(1));
  assign refill_amt = me_value(rate_m_q, {1'b0, rate_e_q});

  shp_tick_div #(.DIV_MAX(DIV_MAX), .DIVX_W(DIVX_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cfg_load),
    .base_tick  (base_tick),
    .div_exp    (div_q),
    .refill_evt (refill_evt)
  );

  shp_cost #(.LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_cost (
    .pkt_len    (pkt_len),
    .count_mode (pkt_count_mode),
    .adj        (adj_q),
    .cost       (cost)
  );

  shp_bucket u_bucket (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .new_cap    (new_cap),
    .refill_evt (refill_evt),
    .refill_amt (refill_amt),
    .send       (pkt_send),
    .cost       (cost),
    .conform    (pkt_conform),
    .credit     (credit)
  );

  assign credit_level = credit;

  AST_ADJ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_q >= ADJ_LO) && (adj_q <= ADJ_HI)); // R10

endmodule

// File: tb/sim_mx_shaper.sv
module sim_mx_shaper;

  logic        clk, rst_n;
  logic        cfg_load;
  logic [7:0]  cfg_rate_mant, cfg_burst_mant;
  logic [3:0]  cfg_rate_exp, cfg_div_exp, cfg_burst_exp;
  logic signed [8:0] cfg_len_adj;
  logic        base_tick;
  logic [15:0] pkt_len;
  logic        pkt_count_mode, pkt_send;
  logic        pkt_conform;
  logic [25:0] credit_level;

  int checks = 0;
  int errors = 0;

  mx_shaper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_rate_mant(cfg_rate_mant), .cfg_rate_exp(cfg_rate_exp),
    .cfg_div_exp(cfg_div_exp), .cfg_burst_mant(cfg_burst_mant),
    .cfg_burst_exp(cfg_burst_exp), .cfg_len_adj(cfg_len_adj),
    .base_tick(base_tick), .pkt_len(pkt_len),
    .pkt_count_mode(pkt_count_mode), .pkt_send(pkt_send),
    .pkt_conform(pkt_conform), .credit_level(credit_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int rm, input int re, input int dv,
                      input int bm, input int be, input int adj);
    @(negedge clk);
    cfg_rate_mant = 8'(rm); cfg_rate_exp = 4'(re); cfg_div_exp = 4'(dv);
    cfg_burst_mant = 8'(bm); cfg_burst_exp = 4'(be); cfg_len_adj = 9'(adj);
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic cyc(input logic tick, input logic send, input int len, input logic mode);
    @(negedge clk);
    base_tick = tick; pkt_send = send; pkt_len = 16'(len); pkt_count_mode = mode;
    @(posedge clk); #1;
    base_tick = 1'b0; pkt_send = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 1'b0);
  endtask

  task automatic peek(input int len, input logic mode, input logic exp, input string req);
    @(negedge clk);
    pkt_send = 1'b0; pkt_len = 16'(len); pkt_count_mode = mode;
    #1 chk(req, longint'(pkt_conform), longint'(exp));
  endtask

  task automatic t_reset;
    chk("R1 reset level", credit_level, 512);
    peek(0, 1'b1, 1'b1, "R9 unit cost conforms");
    peek(3, 1'b0, 1'b0, "R7 byte cost 768 over 512");
    ticks(1);
    chk("R1 reset refill 256 saturates", credit_level, 512);
  endtask

  task automatic t_basic;
    load(0, 0, 0, 0, 4, 0);
    chk("R2 cap 8192", credit_level, 8192);
    cyc(1'b0, 1'b1, 20, 1'b0);
    chk("R8 debit 20 units", credit_level, 3072);
    peek(20, 1'b0, 1'b0, "R7 not enough");
    cyc(1'b0, 1'b1, 20, 1'b0);
    chk("R7 reject holds", credit_level, 3072);
    ticks(4);
    chk("R3 four refills of 256", credit_level, 4096);
    ticks(40);
    chk("R6 saturate at cap", credit_level, 8192);
    cyc(1'b1, 1'b1, 0, 1'b1);
    chk("R11 refill sat then debit", credit_level, 7936);
  endtask

  task automatic t_divider;
    load(1, 0, 2, 0, 4, 0);
    ticks(2);
    load(1, 0, 2, 0, 4, 0);
    cyc(1'b0, 1'b1, 32, 1'b0);
    chk("R7 equal cost conforms", credit_level, 0);
    ticks(3);
    chk("R4 R2 no refill before 4th tick", credit_level, 0);
    ticks(1);
    chk("R3 fractional refill 257", credit_level, 257);
  endtask

  task automatic t_clamp;
    load(0, 0, 15, 0, 0, 0);
    chk("R2 cap 512", credit_level, 512);
    cyc(1'b0, 1'b1, 0, 1'b1);
    cyc(1'b0, 1'b1, 0, 1'b1);
    chk("R9 two unit debits", credit_level, 0);
    ticks(4095);
    chk("R5 none by tick 4095", credit_level, 0);
    ticks(1);
    chk("R5 refill on tick 4096", credit_level, 256);
  endtask

  task automatic t_maxrate;
    load(255, 15, 0, 255, 15, 0);
    chk("R2 max cap", credit_level, 33488896);
    cyc(1'b0, 1'b1, 65535, 1'b0);
    chk("R8 max length debit", credit_level, 16711936);
    ticks(1);
    chk("R3 max refill", credit_level, 33456384);
    ticks(1);
    chk("R6 saturate max", credit_level, 33488896);
  endtask

  task automatic t_adjust;
    load(0, 0, 0, 0, 7, -10);
    cyc(1'b0, 1'b1, 30, 1'b0);
    chk("R10 adj -10", credit_level, 60416);
    load(0, 0, 0, 0, 7, 255);
    cyc(1'b0, 1'b1, 1, 1'b0);
    chk("R10 adj +255", credit_level, 0);
    load(0, 0, 0, 0, 7, -100);
    cyc(1'b0, 1'b1, 70, 1'b0);
    chk("R10 adj clamp to -59", credit_level, 62720);
    peek(5, 1'b0, 1'b1, "R10 negative length conforms");
    cyc(1'b0, 1'b1, 5, 1'b0);
    chk("R10 floor zero cost", credit_level, 62720);
    cyc(1'b0, 1'b1, 1000, 1'b1);
    chk("R9 unit cost ignores len", credit_level, 62464);
    @(negedge clk);
    cfg_load = 1'b1; pkt_send = 1'b1; pkt_len = 16'd10; pkt_count_mode = 1'b0;
    @(posedge clk); #1;
    cfg_load = 1'b0; pkt_send = 1'b0;
    chk("R11 load overrides send", credit_level, 65536);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; base_tick = 1'b0; pkt_send = 1'b0;
    pkt_len = '0; pkt_count_mode = 1'b0;
    cfg_rate_mant = '0; cfg_rate_exp = '0; cfg_div_exp = '0;
    cfg_burst_mant = '0; cfg_burst_exp = '0; cfg_len_adj = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset;
    t_basic;
    t_divider;
    t_clamp;
    t_maxrate;
    t_adjust;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule